// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets a host read and write the 16-bit registers of an external Ethernet PHY over the two-wire management bus. The bus has a clock line and a bidirectional data line. A host places a one-cycle request on a simple port. The request carries a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then serializes a complete management frame. It generates the bus clock by dividing the system clock, and it steers the output enable of the tri-state data pad field by field.

A frame consists of several fields sent in a fixed order:

- a run of ones as preamble;
- a start pattern;
- an opcode;
- the two addresses;
- a two-bit turnaround;
- sixteen data bits.

On writes the master drives every field. On reads it lets go of the line at the turnaround, and it samples the PHY's data bits on the rising bus clock edge. Both frame types close with a short idle stretch during which the line is released. The end of the frame is marked by a single-cycle done pulse. After a read, the captured word stays on the read-data port until the next request is taken.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `mdc_o`, `mdio_oe_o`, `busy_o` and `done_o` are all low.
- R2: A request is taken when `req_i` is high while `busy_o` is low. `busy_o` is high from the next cycle for exactly (64+IDLE_BITS)·2·DIV_HALF cycles. `done_o` pulses high for one cycle in the cycle where `busy_o` drops.
- R3: Each bit slot lasts 2·DIV_HALF cycles, with `mdc_o` low for the first half and high for the second. A frame has 64+IDLE_BITS slots. `mdc_o` stays low while `busy_o` is low.
- R4: `mdio_o` changes only while `mdc_o` is low. Slots 0–31 carry a driven preamble of ones.
- R5: Slots 32–33 carry 0 then 1. Slots 34–35 carry the opcode: 1,0 for a read (`wr_i`=0) and 0,1 for a write (`wr_i`=1).
- R6: Slots 36–40 carry the PHY address and slots 41–45 the register address, each MSB first and driven.
- R7: On a write, slots 46–47 are driven as 1 then 0. Slots 48–63 carry `wdata_i` MSB first, with `mdio_oe_o` high through slot 63.
- R8: On a read, `mdio_oe_o` is low from slot 46 onward. `mdio_i` is sampled at the `mdc_o` rising edge of slots 48–63, and the first sample becomes bit 15 of `rdata_o`.
- R9: `rdata_o` holds the captured word from the done pulse until the next request is taken. After a write frame it reads zero.
- R10: `mdio_oe_o` is low during the idle slots 64 and above.
- R11: A request arriving while `busy_o` is high is ignored. It changes nothing on the line and produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| wr_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress, including idle slots |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 16 | Captured read word |
| mdc_o | output | 1 | Management bus clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from pad |

## Verification
With DIV_HALF=4 and IDLE_BITS=2, `busy_o` is seen one cycle after the request edge. The done pulse follows 528 cycles later. Slot k's line value is settled from the slot's first edge, so it is compared at the k-th rising edge of `mdc_o`, read after that edge at the falling system clock. Read bits are offered by the bench's PHY model half a system cycle after the previous rising edge, well before the master's sampling edge. The scoreboard compares each frame's recorded slots, busy length and read word only when the matching done pulse arrives. The hold of `rdata_o` is checked 30 cycles later.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int FW         = $clog2(FRAME_BITS);
  localparam int TA_SLOT    = 46;
  localparam int DATA_SLOT  = 48;
  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

  // whole frame, slot 0 in the MSB
  function automatic logic [FRAME_BITS-1:0] pack_frame(input logic is_rd,
      input logic [4:0] phy, input logic [4:0] rga, input logic [15:0] wd);
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] dat;
    opc = is_rd ? OPC_RD : OPC_WR;
    ta  = is_rd ? 2'b11 : 2'b10;
    dat = is_rd ? 16'h0000 : wd;
    return {32'hFFFF_FFFF, 2'b01, opc, phy, rga, ta, dat};
  endfunction

  // whether the master owns the line in a given slot
  function automatic logic master_drives(input logic is_rd, input int slot);
    return (slot < TA_SLOT) || (!is_rd && slot < FRAME_BITS);
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_n_i,
  output logic slot_end_o,
  output logic rise_evt_o,
  output logic mdc_o
);
  localparam int SLOT = 2 * DIV_HALF;
  localparam int DW   = $clog2(SLOT);

  logic [DW-1:0] div_q, div_n;
  logic          mdc_q;

  assign slot_end_o = (div_q == DW'(SLOT - 1));
  assign rise_evt_o = (div_q == DW'(DIV_HALF - 1));

  always_comb begin
    if (restart_i || !run_n_i || slot_end_o) div_n = '0;
    else                                     div_n = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      div_q <= div_n;
      mdc_q <= run_n_i && (div_n >= DW'(DIV_HALF));
    end
  end

  assign mdc_o = mdc_q;

  p_rise_on_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(rise_evt_o));
  p_mdc_low_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_n_i |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int IDLE_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        slot_end_i,
  input  logic        rise_evt_i,
  input  logic        mdio_i,
  output logic        accept_o,
  output logic        run_n_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        mdo_o,
  output logic        oe_o,
  output logic [15:0] rdata_o
);
  localparam int TOTAL = FRAME_BITS + IDLE_BITS;
  localparam int BW    = $clog2(TOTAL + 1);

  logic [BW-1:0]         bit_q, bit_n;
  logic [FRAME_BITS-1:0] frame_q, frame_n;
  logic                  rd_q, rd_n;
  logic                  busy_q, busy_n, done_q, mdo_q, mdo_n, oe_q, oe_n;
  logic [15:0]           cap_q;
  logic                  accept, frame_end, grab;

  always_comb begin
    accept    = req_i && !busy_q;
    frame_end = busy_q && slot_end_i && (bit_q == BW'(TOTAL - 1));
    busy_n    = accept || (busy_q && !frame_end);
    if (accept)                    bit_n = '0;
    else if (busy_q && slot_end_i) bit_n = bit_q + 1'b1;
    else                           bit_n = bit_q;
    frame_n = accept ? pack_frame(!wr_i, phy_i, reg_i, wdata_i) : frame_q;
    rd_n    = accept ? !wr_i : rd_q;
    mdo_n   = 1'b0;
    if (busy_n && int'(bit_n) < FRAME_BITS)
      mdo_n = frame_n[FW'(FRAME_BITS - 1 - int'(bit_n))];
    oe_n = busy_n && master_drives(rd_n, int'(bit_n));
    grab = busy_q && rd_q && rise_evt_i &&
           int'(bit_q) >= DATA_SLOT && int'(bit_q) < FRAME_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      cap_q   <= '0;
    end else begin
      bit_q   <= bit_n;
      frame_q <= frame_n;
      rd_q    <= rd_n;
      busy_q  <= busy_n;
      done_q  <= frame_end;
      mdo_q   <= mdo_n;
      oe_q    <= oe_n;
      if (accept)    cap_q <= '0;
      else if (grab) cap_q <= {cap_q[14:0], mdio_i};
    end
  end

  assign accept_o = accept;
  assign run_n_o  = busy_n;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign mdo_o    = mdo_q;
  assign oe_o     = oe_q;
  assign rdata_o  = cap_q;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_at_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_i) |=> ($stable(frame_q) && $stable(rd_q)));
  p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && int'(bit_q) >= TA_SLOT) |-> !oe_q);
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && int'(bit_q) >= FRAME_BITS) |-> !oe_q);
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !accept) |=> $stable(cap_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int DIV_HALF  = 4,
  parameter int IDLE_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic accept, run_n, slot_end, rise_evt;

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (accept),
    .run_n_i    (run_n),
    .slot_end_o (slot_end),
    .rise_evt_o (rise_evt),
    .mdc_o      (mdc_o)
  );

  mdio_frame_seq #(.IDLE_BITS(IDLE_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .wr_i       (wr_i),
    .phy_i      (phy_addr_i),
    .reg_i      (reg_addr_i),
    .wdata_i    (wdata_i),
    .slot_end_i (slot_end),
    .rise_evt_i (rise_evt),
    .mdio_i     (mdio_i),
    .accept_o   (accept),
    .run_n_o    (run_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mdo_o      (mdio_o),
    .oe_o       (mdio_oe_o),
    .rdata_o    (rdata_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdc_o && !mdio_oe_o));
  p_mdo_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc_o);
  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
  localparam int HALF      = 4;
  localparam int IDLE      = 2;
  localparam int SLOTS     = 64 + IDLE;
  localparam int FRAME_CYC = SLOTS * 2 * HALF;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] rdv;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [4:0] phy = '0, rga = '0;
  logic [15:0] wd = '0;
  logic busy, done, mdc, mdo, oe, mdi;
  logic [15:0] rdata;
  logic phy_en = 1'b0, phy_bit = 1'b0;

  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0, done_cnt = 0;
  logic got_mdo [0:SLOTS+3];
  logic got_oe  [0:SLOTS+3];
  int slot = 0, cyc = 0;
  logic prev_busy = 1'b0, prev_mdc = 1'b0, prev_mdo = 1'b0, bad_edge = 1'b0, idle_bad = 1'b0;

  always #2.5 clk = ~clk;

  assign mdi = phy_en ? phy_bit : (oe ? mdo : 1'b1);

  mdio_mgmt_master #(.DIV_HALF(HALF), .IDLE_BITS(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr),
    .phy_addr_i(phy), .reg_addr_i(rga), .wdata_i(wd),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(oe), .mdio_i(mdi)
  );

  task automatic check(input bit ok, input string tag, input logic [159:0] act, input logic [159:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // expected {oe, mdo} of slot k, written field by field
  function automatic logic [1:0] exp_slot(input item_t it, input int k);
    if (k < 32)       return 2'b11;
    else if (k == 32) return 2'b10;
    else if (k == 33) return 2'b11;
    else if (k == 34) return {1'b1, it.rd};
    else if (k == 35) return {1'b1, !it.rd};
    else if (k < 41)  return {1'b1, it.phy[40-k]};
    else if (k < 46)  return {1'b1, it.rg[45-k]};
    else if (k == 46) return it.rd ? 2'b00 : 2'b11;
    else if (k == 47) return it.rd ? 2'b00 : 2'b10;
    else if (k < 64)  return it.rd ? 2'b00 : {1'b1, it.wd[63-k]};
    else              return 2'b00;
  endfunction

  task automatic cmp_range(input item_t it, input int lo, input int hi, input string tag);
    logic [159:0] a = '0, e = '0;
    for (int k = lo; k <= hi; k++) begin
      logic [1:0] ev;
      ev = exp_slot(it, k);
      a = {a[157:0], got_oe[k], ev[1] ? got_mdo[k] : 1'b0};
      e = {e[157:0], ev};
    end
    check(a == e, tag, a, e);
  endtask

  // monitor and PHY model, sampled on falling system clock edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        slot = 0; cyc = 1; bad_edge = 1'b0;
      end else if (busy) cyc++;
      if (!busy && (mdc || oe)) idle_bad = 1'b1;
      if (busy && mdc && mdo !== prev_mdo) bad_edge = 1'b1;
      if (mdc && !prev_mdc) begin
        if (slot < SLOTS + 4) begin
          got_mdo[slot] = mdo;
          got_oe[slot]  = oe;
        end
        if (exp_q.size() > 0 && exp_q[0].rd) begin
          if (slot >= 46 && slot <= 62) begin
            phy_en  = 1'b1;
            phy_bit = (slot == 46) ? 1'b0 : exp_q[0].rdv[62-slot];
          end else phy_en = 1'b0;
        end else phy_en = 1'b0;
        slot++;
      end
      if (done) begin
        done_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected done", 1, 0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          check(cyc == FRAME_CYC && !busy, "R2 busy length", cyc, FRAME_CYC);
          check(slot == SLOTS, "R3 mdc rises per frame", slot, SLOTS);
          check(!bad_edge, "R4 mdio change while mdc high", bad_edge, 0);
          cmp_range(it, 0, 31, "R4 preamble");
          cmp_range(it, 32, 35, "R5 start and opcode");
          cmp_range(it, 36, 45, "R6 addresses");
          cmp_range(it, 46, 63, it.rd ? "R8 read release" : "R7 write turnaround and data");
          cmp_range(it, 64, SLOTS - 1, "R10 idle release");
          if (it.rd) check(rdata == it.rdv, "R8 read sample", rdata, it.rdv);
          else       check(rdata == 16'h0, "R9 rdata after write", rdata, 0);
        end
      end
      prev_busy = busy; prev_mdc = mdc; prev_mdo = mdo;
    end
  end

  task automatic send(input logic rd, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] w, input logic [15:0] rv, input bit extra);
    int start;
    item_t it;
    it = '{rd: rd, phy: p, rg: r, wd: w, rdv: rv};
    exp_q.push_back(it);
    start = done_cnt;
    @(negedge clk);
    req = 1'b1; wr = !rd; phy = p; rga = r; wd = w;
    @(negedge clk);
    req = 1'b0; phy = ~p; rga = ~r; wd = ~w; wr = rd;
    if (extra) begin
      repeat (100) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (done_cnt == start) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!mdc && !oe && !busy && !done, "R1 reset state", {mdc, oe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!mdc && !oe && !busy, "R1 idle after reset", {mdc, oe, busy}, 0);

    send(1'b0, 5'h01, 5'h00, 16'hA5C3, 16'h0, 1'b0);
    send(1'b1, 5'h1F, 5'h15, 16'h0, 16'h8001, 1'b0);
    repeat (30) @(negedge clk);
    check(rdata == 16'h8001, "R9 rdata hold", rdata, 16'h8001);
    send(1'b0, 5'h00, 5'h1F, 16'h0000, 16'h0, 1'b0);
    send(1'b1, 5'h10, 5'h01, 16'h0, 16'hFFFF, 1'b0);
    send(1'b0, 5'h0A, 5'h05, 16'h1234, 16'h0, 1'b1);
    begin
      int d0;
      d0 = done_cnt;
      repeat (600) @(negedge clk);
      check(done_cnt == d0 && !busy, "R11 ignored request", done_cnt, d0);
    end
    send(1'b1, 5'h15, 5'h0A, 16'h0, 16'h5A3C, 1'b1);
    repeat (30) @(negedge clk);
    check(rdata == 16'h5A3C, "R9 rdata hold", rdata, 16'h5A3C);
    send(1'b0, 5'h1E, 5'h11, 16'hFFFF, 16'h0, 1'b0);
    repeat (600) @(negedge clk);
    check(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 0);
    check(!idle_bad, "R3 mdc and oe low between frames", idle_bad, 0);
    finish_run();
  end
endmodule